// File: doc/BRIEF.md
# Indirect Interrupt Routing Table Registers

This block holds the configuration for a bank of interrupt pins and makes it reachable through just two 32-bit bus locations. One location is an index selector. The other is a data window that reads or writes whatever register the selector names. Behind the window are a small identity register, a fixed version word, an arbitration word that mirrors the identity, and one 64-bit routing entry per interrupt pin. Each routing entry is reached as a pair of 32-bit halves.

The whole routing table is driven out in parallel to a downstream delivery engine. That engine reports back through per-pin strobes. These strobes own two status bits in every entry: a "remote request pending" flag and a "delivery in progress" flag. Software can read both bits but cannot write them. When a window write alters an entry field other than the mask or the polarity, the block raises a one-cycle notice. Other agents use it to know that the trigger configuration has to be re-evaluated.

Top module: `irq_route_window`

## Requirements
- R1: Only requests with size 4 at offset 0x00 (selector) or offset 0x10 (window) take effect. Any other size or offset returns 0 on a read and leaves all state unchanged on a write.
- R2: A write to the selector stores all 32 bits, and a selector read returns them. Window accesses act on the register whose index is bits 7:0 of the selector value held before that access.
- R3: Index 0x00 is the identity register. A write keeps only data bits 27:24, and a read returns those four bits in place with every other bit 0. Index 0x02 (arbitration) reads the same word as index 0x00.
- R4: Index 0x01 (version) reads ((ENTRIES-1) << 16) | 0x11, which is 0x00170011 for 24 pins. Writes to index 0x01 or index 0x02 change nothing.
- R5: Pin p occupies index 0x10+2p for entry bits 31:0 and index 0x11+2p for bits 63:32. The output route_table carries pin p in bits [64p+63:64p].
- R6: After reset every entry holds 0x0001000000010000, meaning the mask bit 16 is set. The selector and the identity are 0.
- R7: Entry bits 14 (remote pending) and 12 (delivery in progress) are not changed by a window write, which replaces every other bit of the addressed half.
- R8: A window read at an index that is not 0x00, 0x01, 0x02 or inside 0x10..0x10+2*ENTRIES-1 returns 0.
- R9: cfg_changed is high for the one cycle after a window write that changes any entry bit other than bit 16 (mask) and bit 13 (polarity), with cfg_pin naming that pin. A write that changes only those bits, or nothing, does not raise it.
- R10: eng_irr_set[p] sets bit 14 of pin p at the next edge, and eng_irr_clr[p] clears it (set wins when both are high). Bit 12 of pin p follows eng_busy[p] with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset of the request |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current request, 0 when not reading |
| eng_irr_set | input | ENTRIES | Per-pin strobe that sets the remote-pending bit |
| eng_irr_clr | input | ENTRIES | Per-pin strobe that clears the remote-pending bit |
| eng_busy | input | ENTRIES | Per-pin delivery-in-progress level |
| route_table | output | ENTRIES*64 | All routing entries, pin 0 in the low bits |
| cfg_changed | output | 1 | One-cycle notice of a trigger-relevant entry change |
| cfg_pin | output | PIN_W | Pin that the notice refers to |

## Verification
The hardest situation to reach is a window write landing on an entry whose protected bits are already set. Those bits can only be set from the engine side, so a port-level write alone can never expose a failure to preserve them. The stimulus therefore first pulses the engine's set strobe and the busy level for a pin, then writes zeros through the window. It reads the half back to confirm that the protected bits survived and that clearing only the mask raised no change notice. Separately, pairs of writes that differ only in mask and polarity are checked against pairs that differ in the vector field, to separate the two cases of the notice.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned ENT_W  = 64;

   // Entry bit positions that the block itself interprets
   localparam int unsigned B_DSTAT = 12;
   localparam int unsigned B_POL   = 13;
   localparam int unsigned B_RIRR  = 14;
   localparam int unsigned B_MASK  = 16;

   localparam logic [ENT_W-1:0] ENT_RESET  = 64'h0001_0000_0001_0000;
   localparam logic [ENT_W-1:0] RO_BITS    = (64'd1 << B_RIRR) | (64'd1 << B_DSTAT);
   localparam logic [ENT_W-1:0] CHG_EXEMPT = (64'd1 << B_MASK) | (64'd1 << B_POL);

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_TBL
   } tgt_e;

   typedef struct packed {
      logic sel_rd;
      logic sel_wr;
      logic win_rd;
      logic win_wr;
   } acc_t;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned SEL_OFF  = 'h00,
   parameter int unsigned WIN_OFF  = 'h10,
   parameter int unsigned ENTRIES  = 24,
   parameter int unsigned TBL_BASE = 'h10,
   parameter int unsigned ID_IDX   = 'h00,
   parameter int unsigned VER_IDX  = 'h01,
   parameter int unsigned ARB_IDX  = 'h02,
   parameter int unsigned PIN_W    = 5
) (
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [OFF_W-1:0] req_offset,
   input  logic [2:0]       req_size,
   input  logic [7:0]       idx,
   output acc_t             acc,
   output tgt_e             tgt,
   output logic [PIN_W-1:0] pin,
   output logic             hi
);

   localparam int unsigned TBL_END = TBL_BASE + 2 * ENTRIES;

   logic       ok_size;
   logic       at_sel;
   logic       at_win;
   logic [8:0] idx_ext;
   logic [7:0] rel;

   always_comb begin
      ok_size = req_valid && (req_size == 3'd4);
      at_sel  = (req_offset == OFF_W'(SEL_OFF));
      at_win  = (req_offset == OFF_W'(WIN_OFF));

      acc.sel_rd = ok_size && !req_write && at_sel;
      acc.sel_wr = ok_size &&  req_write && at_sel;
      acc.win_rd = ok_size && !req_write && at_win;
      acc.win_wr = ok_size &&  req_write && at_win;

      idx_ext = {1'b0, idx};
      rel     = idx - 8'(TBL_BASE);
      pin     = rel[PIN_W:1];
      hi      = rel[0];

      if (idx == 8'(ID_IDX))
         tgt = TGT_ID;
      else if (idx == 8'(VER_IDX))
         tgt = TGT_VER;
      else if (idx == 8'(ARB_IDX))
         tgt = TGT_ARB;
      else if (idx_ext >= 9'(TBL_BASE) && idx_ext < 9'(TBL_END))
         tgt = TGT_TBL;
      else
         tgt = TGT_NONE;
   end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
   import irq_route_pkg::*;
#(
   parameter logic [ENT_W-1:0] RESET_VAL = ENT_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wdata,
   input  logic              irr_set,
   input  logic              irr_clr,
   input  logic              busy,
   output logic [ENT_W-1:0]  ent_q,
   output logic              changed
);

   logic [ENT_W-1:0] wmask;
   logic [ENT_W-1:0] sw_next;
   logic [ENT_W-1:0] ent_d;

   always_comb begin
      wmask = '0;
      if (wr_hi)
         wmask[ENT_W-1:WORD_W] = '1;
      else if (wr_lo)
         wmask[WORD_W-1:0] = '1;
      wmask = wmask & ~RO_BITS;

      sw_next = (ent_q & ~wmask) | ({wdata, wdata} & wmask);
      changed = |((sw_next ^ ent_q) & ~CHG_EXEMPT);

      ent_d = sw_next;
      if (irr_set)
         ent_d[B_RIRR] = 1'b1;
      else if (irr_clr)
         ent_d[B_RIRR] = 1'b0;
      ent_d[B_DSTAT] = busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ent_q <= RESET_VAL;
      else
         ent_q <= ent_d;
   end

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
   import irq_route_pkg::*;
#(
   parameter int unsigned ENTRIES  = 24,
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned SEL_OFF  = 'h00,
   parameter int unsigned WIN_OFF  = 'h10,
   parameter int unsigned TBL_BASE = 'h10,
   parameter int unsigned ID_LSB   = 24,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned VER_CODE = 'h11,
   parameter int unsigned MAXE_LSB = 16,
   localparam int unsigned PIN_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [OFF_W-1:0]         req_offset,
   input  logic [2:0]               req_size,
   input  logic [WORD_W-1:0]        req_wdata,
   output logic [WORD_W-1:0]        rsp_rdata,
   input  logic [ENTRIES-1:0]       eng_irr_set,
   input  logic [ENTRIES-1:0]       eng_irr_clr,
   input  logic [ENTRIES-1:0]       eng_busy,
   output logic [ENTRIES*ENT_W-1:0] route_table,
   output logic                     cfg_changed,
   output logic [PIN_W-1:0]         cfg_pin
);

   localparam logic [WORD_W-1:0] VER_WORD =
      WORD_W'((ENTRIES - 1) << MAXE_LSB) | WORD_W'(VER_CODE);

   initial begin
      assert (TBL_BASE + 2 * ENTRIES <= 256)
         else $error("routing table does not fit in the 8-bit index space");
      assert (PIN_W + 1 <= 8)
         else $error("pin index too wide for the selector");
      assert (ID_LSB + ID_W <= WORD_W)
         else $error("identity field outside the data word");
      assert (TBL_BASE > 2)
         else $error("table overlaps the named registers");
   end

   logic [WORD_W-1:0] sel_q;
   logic [ID_W-1:0]   id_q;
   logic              chg_q;
   logic [PIN_W-1:0]  chg_pin_q;

   acc_t              acc;
   tgt_e              tgt;
   logic [PIN_W-1:0]  pin;
   logic              hi;
   logic [WORD_W-1:0] id_word;

   logic [ENT_W-1:0]  ent_q [ENTRIES];
   logic [ENTRIES-1:0] chg;

   irq_route_decode #(
      .OFF_W   (OFF_W),
      .SEL_OFF (SEL_OFF),
      .WIN_OFF (WIN_OFF),
      .ENTRIES (ENTRIES),
      .TBL_BASE(TBL_BASE),
      .ID_IDX  ('h00),
      .VER_IDX ('h01),
      .ARB_IDX ('h02),
      .PIN_W   (PIN_W)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_offset(req_offset),
      .req_size  (req_size),
      .idx       (sel_q[7:0]),
      .acc       (acc),
      .tgt       (tgt),
      .pin       (pin),
      .hi        (hi)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic hit;
      assign hit = acc.win_wr && (tgt == TGT_TBL) && (pin == PIN_W'(g));

      irq_route_entry #(
         .RESET_VAL(ENT_RESET)
      ) u_ent (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_lo  (hit && !hi),
         .wr_hi  (hit &&  hi),
         .wdata  (req_wdata),
         .irr_set(eng_irr_set[g]),
         .irr_clr(eng_irr_clr[g]),
         .busy   (eng_busy[g]),
         .ent_q  (ent_q[g]),
         .changed(chg[g])
      );

      assign route_table[g*ENT_W +: ENT_W] = ent_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= '0;
         id_q      <= '0;
         chg_q     <= 1'b0;
         chg_pin_q <= '0;
      end else begin
         if (acc.sel_wr)
            sel_q <= req_wdata;
         if (acc.win_wr && tgt == TGT_ID)
            id_q <= req_wdata[ID_LSB +: ID_W];
         chg_q <= |chg;
         if (|chg)
            chg_pin_q <= pin;
      end
   end

   assign id_word = WORD_W'(id_q) << ID_LSB;

   always_comb begin
      rsp_rdata = '0;
      if (acc.sel_rd) begin
         rsp_rdata = sel_q;
      end else if (acc.win_rd) begin
         case (tgt)
            TGT_ID:  rsp_rdata = id_word;
            TGT_VER: rsp_rdata = VER_WORD;
            TGT_ARB: rsp_rdata = id_word;
            TGT_TBL: rsp_rdata = hi ? ent_q[pin][ENT_W-1:WORD_W]
                                    : ent_q[pin][WORD_W-1:0];
            default: rsp_rdata = '0;
         endcase
      end
   end

   assign cfg_changed = chg_q;
   assign cfg_pin     = chg_pin_q;

endmodule

// File: rtl/irq_route_window_chk.sv
module irq_route_window_chk
   import irq_route_pkg::*;
#(
   parameter int unsigned ENTRIES  = 24,
   parameter int unsigned OFF_W    = 8,
   parameter int unsigned WIN_OFF  = 'h10,
   parameter int unsigned VER_CODE = 'h11,
   parameter int unsigned MAXE_LSB = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_write,
   input logic [OFF_W-1:0]         req_offset,
   input logic [2:0]               req_size,
   input logic [WORD_W-1:0]        rsp_rdata,
   input logic [ENTRIES-1:0]       eng_irr_set,
   input logic [ENTRIES-1:0]       eng_irr_clr,
   input logic [ENTRIES-1:0]       eng_busy,
   input logic [ENTRIES*ENT_W-1:0] route_table,
   input logic                     cfg_changed,
   input logic [WORD_W-1:0]        sel_q
);

   localparam logic [WORD_W-1:0] VER_EXP =
      WORD_W'((ENTRIES - 1) << MAXE_LSB) | WORD_W'(VER_CODE);

   logic [ENTRIES-1:0] irr_vec;
   logic [ENTRIES-1:0] dstat_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_tap
      assign irr_vec[g]   = route_table[g*ENT_W + B_RIRR];
      assign dstat_vec[g] = route_table[g*ENT_W + B_DSTAT];
   end

   // R1
   size_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size != 3'd4) |-> (rsp_rdata == '0));

   // R4
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 3'd4 &&
       req_offset == OFF_W'(WIN_OFF) && sel_q[7:0] == 8'h01) |-> (rsp_rdata == VER_EXP));

   // R7
   ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_irr_set == '0 && eng_irr_clr == '0) |=> $stable(irr_vec));

   // R9
   cfg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_changed |-> $past(req_valid && req_write && req_size == 3'd4 &&
                            req_offset == OFF_W'(WIN_OFF)));

   // R10
   busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dstat_vec == $past(eng_busy)));

endmodule

bind irq_route_window irq_route_window_chk #(
   .ENTRIES (ENTRIES),
   .OFF_W   (OFF_W),
   .WIN_OFF (WIN_OFF),
   .VER_CODE(VER_CODE),
   .MAXE_LSB(MAXE_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_offset (req_offset),
   .req_size   (req_size),
   .rsp_rdata  (rsp_rdata),
   .eng_irr_set(eng_irr_set),
   .eng_irr_clr(eng_irr_clr),
   .eng_busy   (eng_busy),
   .route_table(route_table),
   .cfg_changed(cfg_changed),
   .sel_q      (sel_q)
);

// File: tb/irq_route_window_bench.sv
`timescale 1ns/1ps
module irq_route_window_bench;

   localparam int N     = 24;
   localparam int PW    = 5;
   localparam logic [63:0] RST_ENT = 64'h0001_0000_0001_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [7:0]        req_offset = '0;
   logic [2:0]        req_size = '0;
   logic [31:0]       req_wdata = '0;
   logic [31:0]       rsp_rdata;
   logic [N-1:0]      eng_irr_set = '0;
   logic [N-1:0]      eng_irr_clr = '0;
   logic [N-1:0]      eng_busy = '0;
   logic [N*64-1:0]   route_table;
   logic              cfg_changed;
   logic [PW-1:0]     cfg_pin;

   int vec_cnt = 0;
   int bad_cnt = 0;

   always #10 clk = ~clk;

   irq_route_window u_irq_route_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_offset (req_offset),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .rsp_rdata  (rsp_rdata),
      .eng_irr_set(eng_irr_set),
      .eng_irr_clr(eng_irr_clr),
      .eng_busy   (eng_busy),
      .route_table(route_table),
      .cfg_changed(cfg_changed),
      .cfg_pin    (cfg_pin)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         bad_cnt++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [7:0] off, logic [2:0] sz, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1;
      req_offset = off; req_size = sz; req_wdata = d;
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] off, logic [2:0] sz, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0;
      req_offset = off; req_size = sz;
      #2;
      d = rsp_rdata;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic win_rd(logic [7:0] idx, output logic [31:0] d);
      bus_wr(8'h00, 3'd4, {24'h0, idx});
      bus_rd(8'h10, 3'd4, d);
   endtask

   task automatic win_wr(logic [7:0] idx, logic [31:0] v);
      bus_wr(8'h00, 3'd4, {24'h0, idx});
      bus_wr(8'h10, 3'd4, v);
   endtask

   function automatic logic [63:0] ent(int p);
      return route_table[p*64 +: 64];
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      for (int p = 0; p < N; p++)
         check("R6 reset entry", ent(p), RST_ENT);
      bus_rd(8'h00, 3'd4, d);
      check("R6 reset selector", 64'(d), 64'h0);
      bus_rd(8'h10, 3'd4, d);
      check("R6 reset identity", 64'(d), 64'h0);
   endtask

   task automatic t_filter();
      logic [31:0] d;
      bus_wr(8'h00, 3'd2, 32'h0000_0011);
      bus_rd(8'h00, 3'd4, d);
      check("R1 selector write size 2 dropped", 64'(d), 64'h0);
      bus_wr(8'h04, 3'd4, 32'h0000_0011);
      bus_rd(8'h00, 3'd4, d);
      check("R1 write at offset 0x04 dropped", 64'(d), 64'h0);
      bus_wr(8'h00, 3'd4, 32'h0000_0001);
      bus_rd(8'h10, 3'd1, d);
      check("R1 window read size 1 is zero", 64'(d), 64'h0);
      bus_rd(8'h14, 3'd4, d);
      check("R1 read at offset 0x14 is zero", 64'(d), 64'h0);
      bus_wr(8'h00, 3'd4, 32'h0000_0000);
      bus_wr(8'h10, 3'd8, 32'hFFFF_FFFF);
      bus_rd(8'h10, 3'd4, d);
      check("R1 window write size 8 dropped", 64'(d), 64'h0);
   endtask

   task automatic t_selector();
      logic [31:0] d;
      bus_wr(8'h00, 3'd4, 32'hABCD_0101);
      bus_rd(8'h00, 3'd4, d);
      check("R2 selector readback", 64'(d), 64'hABCD_0101);
      bus_rd(8'h10, 3'd4, d);
      check("R2 window uses low byte of selector", 64'(d), 64'h0017_0011);
   endtask

   task automatic t_id_arb();
      logic [31:0] d;
      win_wr(8'h00, 32'hFFFF_FFFF);
      bus_rd(8'h10, 3'd4, d);
      check("R3 identity keeps bits 27:24", 64'(d), 64'h0F00_0000);
      win_rd(8'h02, d);
      check("R3 arbitration mirrors identity", 64'(d), 64'h0F00_0000);
      win_wr(8'h00, 32'h0500_0000);
      win_rd(8'h02, d);
      check("R3 arbitration follows new identity", 64'(d), 64'h0500_0000);
   endtask

   task automatic t_version();
      logic [31:0] d;
      win_wr(8'h01, 32'h0000_0000);
      bus_rd(8'h10, 3'd4, d);
      check("R4 version write ignored", 64'(d), 64'h0017_0011);
      win_wr(8'h02, 32'h0F00_0000);
      bus_rd(8'h10, 3'd4, d);
      check("R4 arbitration write ignored", 64'(d), 64'h0500_0000);
      win_rd(8'h00, d);
      check("R4 identity untouched by arb write", 64'(d), 64'h0500_0000);
   endtask

   task automatic t_table_map();
      logic [31:0] d;
      win_wr(8'h1A, 32'h0000_8FA5);
      win_wr(8'h1B, 32'hC800_0000);
      check("R5 pin 5 on route_table", ent(5), 64'hC800_0000_0000_8FA5);
      check("R5 pin 4 untouched", ent(4), RST_ENT);
      check("R5 pin 6 untouched", ent(6), RST_ENT);
      win_rd(8'h1A, d);
      check("R5 pin 5 low half read", 64'(d), 64'h0000_8FA5);
      win_rd(8'h1B, d);
      check("R5 pin 5 high half read", 64'(d), 64'hC800_0000);
      win_wr(8'h3F, 32'h1234_5678);
      check("R5 last pin high half", ent(23), 64'h1234_5678_0001_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      win_rd(8'h03, d);
      check("R8 index 0x03 reads zero", 64'(d), 64'h0);
      win_rd(8'h0F, d);
      check("R8 index 0x0F reads zero", 64'(d), 64'h0);
      win_rd(8'h40, d);
      check("R8 index 0x40 reads zero", 64'(d), 64'h0);
      win_rd(8'hFF, d);
      check("R8 index 0xFF reads zero", 64'(d), 64'h0);
   endtask

   task automatic t_ro_write();
      logic [31:0] d;
      win_wr(8'h18, 32'h1234_5678);
      check("R7 write cannot set bits 14 and 12", ent(4), 64'h0001_0000_1234_0678);
   endtask

   task automatic t_cfg_change();
      bus_wr(8'h00, 3'd4, 32'h0000_0012);
      bus_wr(8'h10, 3'd4, 32'h0000_00A7);
      check("R9 notice after vector change", 64'(cfg_changed), 64'h1);
      check("R9 notice pin", 64'(cfg_pin), 64'd1);
      @(posedge clk); #1;
      check("R9 notice lasts one cycle", 64'(cfg_changed), 64'h0);
      bus_wr(8'h10, 3'd4, 32'h0000_00A7);
      check("R9 identical write gives no notice", 64'(cfg_changed), 64'h0);
      bus_wr(8'h10, 3'd4, 32'h0001_20A7);
      check("R9 mask and polarity change gives no notice", 64'(cfg_changed), 64'h0);
      check("R9 mask and polarity stored", ent(1), 64'h0001_0000_0001_20A7);
      bus_wr(8'h00, 3'd4, 32'h0000_0013);
      bus_wr(8'h10, 3'd4, 32'h5500_0000);
      check("R9 destination change gives notice", 64'(cfg_changed), 64'h1);
   endtask

   task automatic t_engine();
      logic [31:0] d;
      @(negedge clk);
      eng_irr_set[3] = 1'b1;
      eng_busy[3]    = 1'b1;
      @(posedge clk); #1;
      eng_irr_set[3] = 1'b0;
      check("R10 set strobe sets bit 14", 64'(ent(3)[14]), 64'h1);
      check("R10 busy shows on bit 12", 64'(ent(3)[12]), 64'h1);
      win_wr(8'h16, 32'h0000_0000);
      check("R7 protected bits survive zero write", ent(3), 64'h0001_0000_0000_5000);
      check("R7 clearing mask only gives no notice", 64'(cfg_changed), 64'h0);
      win_rd(8'h16, d);
      check("R7 protected bits read back", 64'(d), 64'h0000_5000);
      @(negedge clk);
      eng_irr_clr[3] = 1'b1;
      eng_busy[3]    = 1'b0;
      @(posedge clk); #1;
      eng_irr_clr[3] = 1'b0;
      check("R10 clear strobe clears bit 14", ent(3), 64'h0001_0000_0000_0000);
      @(negedge clk);
      eng_irr_set[7] = 1'b1;
      eng_irr_clr[7] = 1'b1;
      @(posedge clk); #1;
      eng_irr_set[7] = 1'b0;
      eng_irr_clr[7] = 1'b0;
      check("R10 set wins over clear", 64'(ent(7)[14]), 64'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_filter();
      t_selector();
      t_id_arb();
      t_version();
      t_table_map();
      t_unmapped();
      t_ro_write();
      t_cfg_change();
      t_engine();
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

endmodule